// File: doc/BRIEF.md
# Sandcastle and Horizontal Pulse Generator

This block turns a per-line strobe and a field-start strobe into the two timing outputs that a picture-in-picture processor needs from a colour decoder. The first is a horizontal sync pulse. The second is a three-level sandcastle signal that carries burst key, line blanking and vertical blanking on a single pin. The line strobe marks the leading edge of input sync as the line PLL recovers it. Every duration is counted in clock cycles from that strobe, and each count is derived from the clock frequency and a length given in tenths of a microsecond.

The sandcastle leaves the block as a digital state together with an output enable and a data bit. The pad's tri-state driver sits outside. The three states are: driven low during active scan, driven high during burst key, and released (high impedance) during blanking. Burst key wins over blanking when the two overlap.

If no line strobe arrives for a full nominal line period, the block makes its own strobe. Horizontal pulses and sandcastle then carry on at the nominal line rate with no input at all.

Top module: `sandcastle_gen`

## Requirements
- R1: `hout` is high in the clock cycle right after the edge that samples a line strobe, and stays high for exactly HS cycles: 5.4 us, which is 270 cycles at 50 MHz.
- R2: Burst key starts BK_BEG cycles after the strobe edge (5.4 us, 270 cycles) and lasts BK cycles (3.5 us, 175 cycles). During burst key the sandcastle is driven high.
- R3: Line blanking covers the first LB cycles after the strobe edge (8.7 us, 435 cycles). Outside burst key, the sandcastle is high impedance there.
- R4: Outside burst key, line blanking and vertical blanking, the sandcastle is driven low.
- R5: State encoding on `sc_state`: 2'b00 means driven low, 2'b01 means driven high, 2'b10 means high impedance, and 2'b11 never appears. `sc_oe` is 1 exactly for the two driven states. `sc_data` is 1 only for the high state.
- R6: A `vert_start` pulse starts vertical blanking. The block counts the line strobes that follow, and vertical blanking ends at the 14th of them. A `vert_start` in the same cycle as a line strobe loads the count, and that strobe does not count toward the 14.
- R7: Burst key has priority over line blanking and over vertical blanking, so it is driven high for its full length.
- R8: If no external line strobe comes within LINE cycles (64 us, 3200 cycles) of the previous strobe, an internal strobe fires. With no input, `hout` therefore rises every 3200 cycles.
- R9: After reset, `hout` is low and the sandcastle is driven low until the first strobe.
- R10: All durations are computed from `CLK_HZ` and lengths in tenths of a microsecond. Between strobes, the position counter advances by one per cycle.
- R11: A line strobe in the middle of a line restarts all line timing from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_start | input | 1 | One-cycle strobe at the leading edge of recovered sync |
| vert_start | input | 1 | One-cycle strobe at the start of vertical sync |
| hout | output | 1 | Horizontal sync output pulse |
| sc_state | output | 2 | Sandcastle state: 00 low, 01 high, 10 high impedance |
| sc_oe | output | 1 | Enable for the sandcastle pad driver |
| sc_data | output | 1 | Level driven on the sandcastle pad while enabled |

## Verification
Some properties are checked on every cycle by the assertions:
- the legal state encoding and its agreement with the enable and data outputs;
- burst-key priority;
- the position counter restarting on a strobe and advancing by one otherwise;
- the field counter loading and holding;
- the flywheel counter staying in range.

Other behaviour only the bench scenarios can show. These are the absolute edge positions of every window, the 14-strobe extent of vertical blanking when `vert_start` falls inside a line or on a strobe, mid-line restarts, and the 3200-cycle period of the free-running strobe. The bench follows all of these cycle by cycle against its own count of time since the last strobe.

// File: rtl/sandcastle_pkg.sv
package sandcastle_pkg;

  typedef enum logic [1:0] {
    SC_LOW  = 2'b00,
    SC_HIGH = 2'b01,
    SC_HIZ  = 2'b10
  } sc_level_e;

  // length in tenths of a microsecond -> whole clock cycles
  function automatic int unsigned dus_to_cyc(input longint unsigned clk_hz,
                                             input int unsigned dus);
    longint unsigned prod;
    prod = clk_hz * 64'(dus);
    return 32'(prod / 64'd10_000_000);
  endfunction

endpackage

// File: rtl/sc_flywheel.sv
module sc_flywheel #(
  parameter int unsigned LINE_CYC = 3200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_strobe,
  output logic line_strobe,
  output logic fly_fire
);
  localparam int unsigned CW = $clog2(LINE_CYC);
  localparam logic [CW-1:0] LAST = CW'(LINE_CYC - 1);

  logic [CW-1:0] cnt;

  assign fly_fire    = (cnt == LAST) && !ext_strobe;
  assign line_strobe = ext_strobe | fly_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (line_strobe) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  a_r8_fire_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    fly_fire |=> (cnt == '0));

endmodule

// File: rtl/sc_line_timer.sv
module sc_line_timer #(
  parameter int unsigned HS_CYC  = 270,
  parameter int unsigned BK_BEG  = 270,
  parameter int unsigned BK_CYC  = 175,
  parameter int unsigned LB_CYC  = 435,
  parameter int unsigned POS_MAX = 3200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_strobe,
  output logic hs_win,
  output logic bk_win,
  output logic lb_win
);
  localparam int unsigned PW = $clog2(POS_MAX + 1);
  localparam logic [PW-1:0] P_SAT  = PW'(POS_MAX);
  localparam logic [PW-1:0] HS_END = PW'(HS_CYC);
  localparam logic [PW-1:0] BK_LO  = PW'(BK_BEG);
  localparam logic [PW-1:0] BK_HI  = PW'(BK_BEG + BK_CYC);
  localparam logic [PW-1:0] LB_END = PW'(LB_CYC);

  logic [PW-1:0] pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pos <= P_SAT;
    else if (line_strobe)   pos <= '0;
    else if (pos != P_SAT)  pos <= pos + 1'b1;
  end

  assign hs_win = pos < HS_END;
  assign bk_win = (pos >= BK_LO) && (pos < BK_HI);
  assign lb_win = pos < LB_END;

  a_r1_hs_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    line_strobe |=> hs_win);
  a_r11_restart: assert property (@(posedge clk) disable iff (!rst_n)
    line_strobe |=> (pos == '0));
  a_r10_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_strobe && pos != P_SAT) |=> (pos == $past(pos) + 1'b1));

endmodule

// File: rtl/sc_vblank.sv
module sc_vblank #(
  parameter int unsigned VB_LINES = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vert_start,
  input  logic line_strobe,
  output logic vb_win
);
  localparam int unsigned VW = $clog2(VB_LINES + 1);
  localparam logic [VW-1:0] LOAD = VW'(VB_LINES);

  logic [VW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          left <= '0;
    else if (vert_start)                 left <= LOAD;
    else if (line_strobe && left != '0)  left <= left - 1'b1;
  end

  assign vb_win = (left != '0);

  a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
    vert_start |=> (left == LOAD));
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!vert_start && !line_strobe) |=> $stable(left));

endmodule

// File: rtl/sandcastle_gen.sv
module sandcastle_gen
  import sandcastle_pkg::*;
#(
  parameter longint unsigned CLK_HZ = 50_000_000,
  parameter int unsigned HS_DUS     = 54,
  parameter int unsigned BK_BEG_DUS = 54,
  parameter int unsigned BK_DUS     = 35,
  parameter int unsigned LB_DUS     = 87,
  parameter int unsigned LINE_DUS   = 640,
  parameter int unsigned VB_LINES   = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_start,
  input  logic       vert_start,
  output logic       hout,
  output logic [1:0] sc_state,
  output logic       sc_oe,
  output logic       sc_data
);
  localparam int unsigned HS_CYC   = dus_to_cyc(CLK_HZ, HS_DUS);
  localparam int unsigned BK_BEG   = dus_to_cyc(CLK_HZ, BK_BEG_DUS);
  localparam int unsigned BK_CYC   = dus_to_cyc(CLK_HZ, BK_DUS);
  localparam int unsigned LB_CYC   = dus_to_cyc(CLK_HZ, LB_DUS);
  localparam int unsigned LINE_CYC = dus_to_cyc(CLK_HZ, LINE_DUS);

  logic line_strobe, fly_fire;
  logic hs_win, bk_win, lb_win, vb_win;
  sc_level_e lvl;

  sc_flywheel #(.LINE_CYC(LINE_CYC)) u_fly (
    .clk(clk), .rst_n(rst_n), .ext_strobe(line_start),
    .line_strobe(line_strobe), .fly_fire(fly_fire)
  );

  sc_line_timer #(
    .HS_CYC(HS_CYC), .BK_BEG(BK_BEG), .BK_CYC(BK_CYC),
    .LB_CYC(LB_CYC), .POS_MAX(LINE_CYC)
  ) u_line (
    .clk(clk), .rst_n(rst_n), .line_strobe(line_strobe),
    .hs_win(hs_win), .bk_win(bk_win), .lb_win(lb_win)
  );

  sc_vblank #(.VB_LINES(VB_LINES)) u_vb (
    .clk(clk), .rst_n(rst_n), .vert_start(vert_start),
    .line_strobe(line_strobe), .vb_win(vb_win)
  );

  always_comb begin
    if (bk_win)                lvl = SC_HIGH;
    else if (lb_win || vb_win) lvl = SC_HIZ;
    else                       lvl = SC_LOW;
  end

  assign hout     = hs_win;
  assign sc_state = lvl;
  assign sc_oe    = (lvl != SC_HIZ);
  assign sc_data  = (lvl == SC_HIGH);

  a_r5_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    sc_state != 2'b11);
  a_r5_hiz_released: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_state == 2'b10) |-> (!sc_oe && !sc_data));
  a_r5_high_driven: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_state == 2'b01) |-> (sc_oe && sc_data));
  a_r7_burst_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (bk_win && (lb_win || vb_win)) |-> (sc_state == 2'b01));
  a_r8_fly_no_ext: assert property (@(posedge clk) disable iff (!rst_n)
    fly_fire |-> !line_start);

endmodule

// File: tb/sandcastle_gen_test.sv
`timescale 1ns/1ps
module sandcastle_gen_test;
  // expected timing at 50 MHz, from lengths in tenths of a microsecond
  localparam int HS   = (50 * 54) / 10;
  localparam int BKB  = (50 * 54) / 10;
  localparam int BKE  = BKB + (50 * 35) / 10;
  localparam int LB   = (50 * 87) / 10;
  localparam int LINE = (50 * 640) / 10;
  localparam int VBL  = 14;
  localparam int NONE = 1_000_000;

  logic clk = 0, rst_n = 0, line_start = 0, vert_start = 0;
  logic hout, sc_oe, sc_data;
  logic [1:0] sc_state;

  int checks = 0, errors = 0, cyc = 0;
  int since = NONE, gap = 0, vb = 0;
  bit chk_en = 0;
  string phase = "reset";

  sandcastle_gen uut (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .vert_start(vert_start),
    .hout(hout), .sc_state(sc_state), .sc_oe(sc_oe), .sc_data(sc_data)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s] cyc=%0d actual=%0d expected=%0d", req, phase, cyc, act, exp);
    end
  endtask

  // reference timeline: cycles since last strobe, flywheel gap, field lines left
  always @(posedge clk) begin
    if (!rst_n) begin
      since = NONE; gap = 0; vb = 0;
    end else begin
      bit fire;
      fire = line_start || (gap == LINE - 1);
      if (vert_start) vb = VBL;
      else if (fire && vb > 0) vb = vb - 1;
      gap = fire ? 0 : gap + 1;
      if (fire) since = 0;
      else if (since < NONE) since = since + 1;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n && chk_en) begin
      int es; string tag;
      bit eh;
      eh = (since < HS);
      if (since >= BKB && since < BKE) es = 1;
      else if (since < LB || vb > 0) es = 2;
      else es = 0;
      if (es == 1) tag = (since < LB || vb > 0) ? "R7" : "R2";
      else if (es == 2) tag = (vb > 0 && since >= LB) ? "R6" : "R3";
      else tag = "R4";
      check(hout === eh, "R1", int'(hout), int'(eh));
      check(sc_state === 2'(es), tag, int'(sc_state), es);
      check(sc_oe === (es != 2) && sc_data === (es == 1), "R5",
            int'({sc_oe, sc_data}), int'({es != 2, es == 1}));
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input bit ln, input bit vs);
    line_start = ln; vert_start = vs;
    @(negedge clk);
    line_start = 0; vert_start = 0;
  endtask

  initial begin : watchdog
    repeat (200_000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(4);
    // R9: reset values
    check(hout === 1'b0, "R9", int'(hout), 0);
    check(sc_state === 2'b00 && sc_oe === 1'b1, "R9", int'(sc_state), 0);
    rst_n = 1;
    chk_en = 1;

    // R8, R10: free-running period and pulse width with no input
    phase = "R8 free run";
    begin
      int n, hi;
      while (!hout) @(negedge clk);
      n = 0; hi = 0;
      do begin @(negedge clk); n++; if (hout) hi++; end while (hout);
      do begin @(negedge clk); n++; end while (!hout);
      check(n == LINE, "R8", n, LINE);
      check(hi + 1 == HS, "R10", hi + 1, HS);
    end
    step(500);

    phase = "R1 R2 R3 R4 external lines";
    for (int i = 0; i < 3; i++) begin strobe(1, 0); step(1499); end

    phase = "R11 restart inside hout";
    strobe(1, 0); step(100); strobe(1, 0); step(1000);
    phase = "R11 restart inside burst";
    strobe(1, 0); step(300); strobe(1, 0); step(800);

    phase = "R6 vert_start mid line";
    strobe(1, 0); step(50); strobe(0, 1);
    for (int i = 0; i < 16; i++) begin step(949); strobe(1, 0); step(50); end

    phase = "R6 vert_start with strobe";
    strobe(1, 1); step(999);
    for (int i = 0; i < 15; i++) begin strobe(1, 0); step(999); end

    phase = "R8 input lost";
    step(2 * LINE + 600);

    chk_en = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule